// File: doc/BRIEF.md
# Parallel Per-Target Bus Arbitration Fabric

This block connects three bus masters (a CPU at index 0, a DMA engine at index 1 and a crypto engine at index 2) to five memory targets. Each master's address is decoded to exactly one target, and every target owns a private arbiter. Masters that address different targets are therefore all served in the same clock cycle; only masters that collide on one target compete.

Within a target the CPU wins over the DMA engine, which wins over the crypto engine. A per-master wait counter inside each target arbiter removes the risk of starvation: once a lower-priority master has been refused for a set number of consecutive cycles, it is forced through for one access. A refused master sees its ready low and keeps its request, address, write flag and write data steady until ready rises. A transfer completes in the cycle in which ready is high; the target returns read data combinationally in that same cycle.

Top module: `mbus_fabric`

## Requirements
- R1: Address decode selects the target: 0x0000–0x0FFF is target 0, 0x1000–0x1FFF is target 1, 0x2000–0x3FFF is target 2, 0x4000–0x7FFF is target 3 and 0x8000–0xFFFF is target 4; bit t of `t_sel` and slice t of `t_gnt` belong to target t.
- R2: Masters that request different targets all see ready high in the same cycle.
- R3: Per target, at most one master is granted per cycle and only a requesting master; `t_sel[t]` is high exactly when target t grants someone, and idle targets stay unselected.
- R4: Without forcing, a contended target grants the lowest-index requester (CPU over DMA over crypto).
- R5: A master refused for `STARVE_LIMIT` (default 4) consecutive cycles on a target while still requesting it is granted in the following cycle; when several are due, the lowest index goes first.
- R6: A master's wait count returns to zero when it is granted or when it stops requesting the target, so a later contention waits the full window again.
- R7: The granted master's address, write flag and write data appear on the target's port, and the target's read data appears on that master's `m_rdata` slice in the same cycle.
- R8: A master whose ready is low has no effect on any target (a refused write changes nothing) and sees zero read data; ready is never high without a request.
- R9: After reset, with no requests, every ready, select and read data output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 3 | Request per master (bit 0 CPU, 1 DMA, 2 crypto) |
| m_addr | input | 48 | 16-bit address per master, master m at bits [16m+15:16m] |
| m_we | input | 3 | Write flag per master |
| m_wdata | input | 3*DATA_W | Write data per master |
| m_ready | output | 3 | Transfer accepted for the master this cycle |
| m_rdata | output | 3*DATA_W | Read data per master, zero while not ready |
| t_sel | output | 5 | Target t is accessed this cycle |
| t_gnt | output | 15 | One-hot granted master per target, target t at bits [3t+2:3t] |
| t_addr | output | 80 | Address routed to each target |
| t_we | output | 5 | Write flag routed to each target |
| t_wdata | output | 5*DATA_W | Write data routed to each target |
| t_rdata | input | 5*DATA_W | Read data returned by each target |

## Verification
The bench builds the fabric with its defaults, an 8-bit data path and a starvation window of 4 cycles, so a forced grant appears within five cycles of contention and repeated forcing fits in a short run. That short window makes it practical to walk the DMA engine through two full starvation periods, to interrupt a half-built wait and show it restarts from zero, and to run a three-way collision where both lower masters become due on the same target. Small register-file target models behind each port let refused writes and routed read data be observed only through the master ports.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int ADDR_W = 16;
    localparam int N_MST  = 3;
    localparam int N_TGT  = 5;

    typedef enum logic [2:0] {
        TGT_BANK0 = 3'd0,
        TGT_BANK1 = 3'd1,
        TGT_SCRAT = 3'd2,
        TGT_XREG  = 3'd3,
        TGT_CODE  = 3'd4
    } tgt_e;

    typedef logic [N_MST-1:0] mvec_t;
    typedef logic [N_TGT-1:0] tvec_t;

    function automatic tgt_e addr_to_tgt(input logic [ADDR_W-1:0] a);
        if (a[15])      return TGT_CODE;
        else if (a[14]) return TGT_XREG;
        else if (a[13]) return TGT_SCRAT;
        else if (a[12]) return TGT_BANK1;
        else            return TGT_BANK0;
    endfunction

    // lowest set bit wins
    function automatic mvec_t lowest_one(input mvec_t v);
        mvec_t res;
        res = '0;
        for (int i = N_MST - 1; i >= 0; i--) begin
            if (v[i]) begin
                res    = '0;
                res[i] = 1'b1;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/mbus_addr_decode.sv
module mbus_addr_decode
    import mbus_pkg::*;
(
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output tvec_t             hit
);
    tgt_e sel;

    always_comb begin
        sel      = addr_to_tgt(addr);
        hit      = '0;
        hit[sel] = req;
    end

    always_comb begin
        if (!req) assert ($onehot0(hit) && hit == '0);           // R1
        else      assert ($countones(hit) == 1);                 // R1
    end
endmodule

// File: rtl/mbus_target_arb.sv
module mbus_target_arb
    import mbus_pkg::*;
#(
    parameter int STARVE_LIMIT = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  mvec_t req,
    output mvec_t gnt
);
    localparam int CW = $clog2(STARVE_LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(STARVE_LIMIT);

    logic [CW-1:0] wait_q [N_MST];
    mvec_t         due;

    always_comb begin
        for (int m = 0; m < N_MST; m++) due[m] = req[m] && (wait_q[m] >= LIM);
    end

    always_comb begin
        if (|due) gnt = lowest_one(due);
        else      gnt = lowest_one(req);
    end

    for (genvar m = 0; m < N_MST; m++) begin : g_wait
        localparam mvec_t BELOW = mvec_t'((32'd1 << m) - 32'd1);

        always_ff @(posedge clk) begin
            if (rst)                    wait_q[m] <= '0;
            else if (req[m] && !gnt[m]) wait_q[m] <= (wait_q[m] == LIM) ? wait_q[m] : wait_q[m] + 1'b1;
            else                        wait_q[m] <= '0;
        end

        AST_DUE_SERVED: assert property (@(posedge clk) disable iff (rst)
            (due[m] && ((due & BELOW) == '0)) |-> gnt[m]);       // R5

        AST_WAIT_CLEARED: assert property (@(posedge clk) disable iff (rst)
            (gnt[m] || !req[m]) |=> (wait_q[m] == '0));          // R6
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));                                          // R3

    AST_GNT_TO_REQ: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);                                     // R3

    AST_BUSY_GRANTS: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> (|gnt));                                      // R3

    AST_CPU_FIRST: assert property (@(posedge clk) disable iff (rst)
        (req[0] && !(|due)) |-> gnt[0]);                         // R4
endmodule

// File: rtl/mbus_fabric.sv
module mbus_fabric
    import mbus_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int STARVE_LIMIT = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_MST-1:0]          m_req,
    input  logic [N_MST*ADDR_W-1:0]   m_addr,
    input  logic [N_MST-1:0]          m_we,
    input  logic [N_MST*DATA_W-1:0]   m_wdata,
    output logic [N_MST-1:0]          m_ready,
    output logic [N_MST*DATA_W-1:0]   m_rdata,
    output logic [N_TGT-1:0]          t_sel,
    output logic [N_TGT*N_MST-1:0]    t_gnt,
    output logic [N_TGT*ADDR_W-1:0]   t_addr,
    output logic [N_TGT-1:0]          t_we,
    output logic [N_TGT*DATA_W-1:0]   t_wdata,
    input  logic [N_TGT*DATA_W-1:0]   t_rdata
);
    tvec_t hit   [N_MST];
    mvec_t req_t [N_TGT];
    mvec_t gnt_t [N_TGT];
    mvec_t alone;

    for (genvar m = 0; m < N_MST; m++) begin : g_dec
        mbus_addr_decode u_dec (
            .req  (m_req[m]),
            .addr (m_addr[m*ADDR_W +: ADDR_W]),
            .hit  (hit[m])
        );
    end

    always_comb begin
        for (int t = 0; t < N_TGT; t++)
            for (int m = 0; m < N_MST; m++) req_t[t][m] = hit[m][t];
    end

    for (genvar t = 0; t < N_TGT; t++) begin : g_arb
        mbus_target_arb #(.STARVE_LIMIT(STARVE_LIMIT)) u_arb (
            .clk (clk),
            .rst (rst),
            .req (req_t[t]),
            .gnt (gnt_t[t])
        );
    end

    // target-side routing
    always_comb begin
        t_addr  = '0;
        t_we    = '0;
        t_wdata = '0;
        for (int t = 0; t < N_TGT; t++) begin
            t_sel[t]                  = |gnt_t[t];
            t_gnt[t*N_MST +: N_MST]   = gnt_t[t];
            for (int m = 0; m < N_MST; m++) begin
                if (gnt_t[t][m]) begin
                    t_addr[t*ADDR_W +: ADDR_W]  = m_addr[m*ADDR_W +: ADDR_W];
                    t_we[t]                     = m_we[m];
                    t_wdata[t*DATA_W +: DATA_W] = m_wdata[m*DATA_W +: DATA_W];
                end
            end
        end
    end

    // master-side routing
    always_comb begin
        m_ready = '0;
        m_rdata = '0;
        for (int m = 0; m < N_MST; m++) begin
            for (int t = 0; t < N_TGT; t++) begin
                if (gnt_t[t][m]) begin
                    m_ready[m]                  = 1'b1;
                    m_rdata[m*DATA_W +: DATA_W] = t_rdata[t*DATA_W +: DATA_W];
                end
            end
        end
    end

    // masters with no competitor on their target
    always_comb begin
        for (int m = 0; m < N_MST; m++) begin
            alone[m] = m_req[m];
            for (int k = 0; k < N_MST; k++)
                if (k != m && (|(hit[m] & hit[k]))) alone[m] = 1'b0;
        end
    end

    AST_LONE_SERVED: assert property (@(posedge clk) disable iff (rst)
        (alone & ~m_ready) == '0);                               // R2

    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        (m_ready & ~m_req) == '0);                               // R8

    AST_SEL_MATCHES_READY: assert property (@(posedge clk) disable iff (rst)
        $countones(t_sel) == $countones(m_ready));               // R3
endmodule

// File: tb/mbus_fabric_tb.sv
module mbus_fabric_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    m_req = '0;
    logic [2:0]    m_we  = '0;
    logic [15:0]   a0 = '0, a1 = '0, a2 = '0;
    logic [7:0]    d0 = '0, d1 = '0, d2 = '0;
    logic [2:0]    m_ready;
    logic [23:0]   m_rdata;
    logic [4:0]    t_sel;
    logic [14:0]   t_gnt;
    logic [79:0]   t_addr;
    logic [4:0]    t_we;
    logic [39:0]   t_wdata;
    logic [39:0]   t_rdata;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    mbus_fabric #(.DATA_W(DW), .STARVE_LIMIT(4)) u_dut (
        .clk(clk), .rst(rst),
        .m_req(m_req), .m_addr({a2, a1, a0}), .m_we(m_we),
        .m_wdata({d2, d1, d0}), .m_ready(m_ready), .m_rdata(m_rdata),
        .t_sel(t_sel), .t_gnt(t_gnt), .t_addr(t_addr), .t_we(t_we),
        .t_wdata(t_wdata), .t_rdata(t_rdata)
    );

    // target register models
    logic [7:0] mem [5][16];

    always_comb begin
        for (int t = 0; t < 5; t++) t_rdata[t*8 +: 8] = mem[t][t_addr[t*16 +: 4]];
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < 5; t++)
                for (int i = 0; i < 16; i++) mem[t][i] <= '0;
        end else begin
            for (int t = 0; t < 5; t++)
                if (t_sel[t] && t_we[t]) mem[t][t_addr[t*16 +: 4]] <= t_wdata[t*8 +: 8];
        end
    end

    typedef struct {
        logic [2:0]  rdy;
        logic [4:0]  sel;
        logic [23:0] rd;
        string       tag;
    } exp_t;

    exp_t exp_q [$];

    task automatic cyc(input logic [2:0] rq, input logic [2:0] w,
                       input logic [15:0] x0, input logic [15:0] x1, input logic [15:0] x2,
                       input logic [7:0] y0, input logic [7:0] y1, input logic [7:0] y2,
                       input logic [2:0] erdy, input logic [4:0] esel,
                       input logic [23:0] erd, input string tag);
        exp_t it;
        @(negedge clk);
        m_req = rq; m_we = w;
        a0 = x0; a1 = x1; a2 = x2;
        d0 = y0; d1 = y1; d2 = y2;
        it.rdy = erdy; it.sel = esel; it.rd = erd; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic idle();
        cyc(3'b000, 3'b000, 0, 0, 0, 0, 0, 0, 3'b000, 5'b00000, 24'h0, "R9 idle");
    endtask

    // monitor / scoreboard
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                total++;
                if (m_ready !== it.rdy) begin
                    bad++;
                    $display("FAIL %s ready got=%b exp=%b", it.tag, m_ready, it.rdy);
                end
                total++;
                if (t_sel !== it.sel) begin
                    bad++;
                    $display("FAIL %s select got=%b exp=%b", it.tag, t_sel, it.sel);
                end
                total++;
                if (m_rdata !== it.rd) begin
                    bad++;
                    $display("FAIL %s rdata got=%h exp=%h", it.tag, m_rdata, it.rd);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: quiet after reset
        idle();

        // R1 R2: parallel writes to three distinct targets
        cyc(3'b111, 3'b111, 16'h0003, 16'h1003, 16'h4003, 8'h11, 8'h22, 8'h33,
            3'b111, 5'b01011, 24'h0, "R2 parallel write");
        cyc(3'b011, 3'b011, 16'h2005, 16'h8005, 0, 8'h44, 8'h55, 0,
            3'b011, 5'b10100, 24'h0, "R1 scratch/code write");
        // R7: read-back routed per master
        cyc(3'b111, 3'b000, 16'h0003, 16'h4003, 16'h1003, 0, 0, 0,
            3'b111, 5'b01011, 24'h223311, "R7 parallel read");
        cyc(3'b011, 3'b000, 16'h8005, 16'h2005, 0, 0, 0, 0,
            3'b011, 5'b10100, 24'h004455, "R1 decode read");

        // R4: CPU beats DMA; refused DMA write must not land
        cyc(3'b011, 3'b011, 16'h0007, 16'h0007, 0, 8'hA1, 8'hB2, 0,
            3'b001, 5'b00001, 24'h0, "R4 cpu over dma");
        idle();
        cyc(3'b001, 3'b000, 16'h0007, 0, 0, 0, 0, 0,
            3'b001, 5'b00001, 24'h0000A1, "R8 refused write ignored");
        // R4: DMA beats crypto
        cyc(3'b110, 3'b000, 0, 16'h1003, 16'h1003, 0, 0, 0,
            3'b010, 5'b00010, 24'h002200, "R4 dma over crypto");
        idle();

        // R5: DMA forced every fifth cycle against a busy CPU
        for (int i = 0; i < 10; i++) begin
            if (i == 4 || i == 9)
                cyc(3'b011, 3'b000, 16'h0003, 16'h0003, 0, 0, 0, 0,
                    3'b010, 5'b00001, 24'h001100, "R5 dma forced");
            else
                cyc(3'b011, 3'b000, 16'h0003, 16'h0003, 0, 0, 0, 0,
                    3'b001, 5'b00001, 24'h000011, "R5 cpu wins");
        end
        idle();

        // R6: dropping the request restarts the wait window
        for (int i = 0; i < 9; i++) begin
            if (i == 3)
                cyc(3'b001, 3'b000, 16'h0003, 0, 0, 0, 0, 0,
                    3'b001, 5'b00001, 24'h000011, "R6 dma dropped");
            else if (i == 8)
                cyc(3'b011, 3'b000, 16'h0003, 16'h0003, 0, 0, 0, 0,
                    3'b010, 5'b00001, 24'h001100, "R6 dma after full window");
            else
                cyc(3'b011, 3'b000, 16'h0003, 16'h0003, 0, 0, 0, 0,
                    3'b001, 5'b00001, 24'h000011, "R6 cpu wins");
        end
        idle();

        // R5: three-way collision, lower index first among due masters
        for (int i = 0; i < 11; i++) begin
            if (i == 4 || i == 9)
                cyc(3'b111, 3'b000, 16'h4003, 16'h4003, 16'h4003, 0, 0, 0,
                    3'b010, 5'b01000, 24'h003300, "R5 dma due first");
            else if (i == 5 || i == 10)
                cyc(3'b111, 3'b000, 16'h4003, 16'h4003, 16'h4003, 0, 0, 0,
                    3'b100, 5'b01000, 24'h330000, "R5 crypto due next");
            else
                cyc(3'b111, 3'b000, 16'h4003, 16'h4003, 16'h4003, 0, 0, 0,
                    3'b001, 5'b01000, 24'h000033, "R5 cpu wins");
        end
        idle();

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule